// File: doc/BRIEF.md
# Variable-length CAN receive message FIFO

This block is a byte-wide circular store for received CAN messages that are already encoded in a packed format. A message is a header byte followed by identifier bytes and data bytes. It enters the block as a burst of bytes, one per clock, and the first beat carries the total length. The block reserves room for the whole message on its first beat. If the message does not fit, the block drops every byte of it and raises an overrun flag.

The consumer sees a small read window. Window address N returns the byte N positions past the start of the oldest stored message. A release pulse discards the oldest message. The amount the start pointer moves is decoded from that message's own header byte, so each release moves it by a different number of bytes. The block also reports the number of reserved bytes, the number of complete messages and a receive-available flag.

Top module: `can_rx_msg_fifo`

## Requirements
- R1: The header byte holds the extended flag in bit 7, the remote flag in bit 6 and the DLC (0 to 8) in bits 3..0. A stored message is 3 bytes plus DLC data bytes when standard, and 5 bytes plus DLC data bytes when extended. A remote message carries no data bytes.
- R2: When the writer is idle, a beat with `in_valid` high and `in_len` nonzero starts a message of `in_len` bytes (1 to DEPTH), and the following `in_len`-1 valid beats complete it. The bytes are stored in order from the write pointer, which wraps modulo DEPTH. `msg_cnt` goes up by one on the edge of the last beat.
- R3: `rd_data` is registered. One clock after `rd_addr` = N is presented, it equals the stored byte at (start + N) modulo DEPTH.
- R4: A release with at least one complete message stored advances the start pointer by the length that R1 decodes from the header at the start pointer, modulo DEPTH. It lowers `byte_cnt` by that length and `msg_cnt` by one.
- R5: A release while `msg_cnt` is zero changes nothing: not the counts and not the start pointer.
- R6: If `byte_cnt` plus `in_len` on a first beat exceeds DEPTH, the whole message is dropped, its remaining beats are consumed without being stored, and `overrun` is set. A message that fills the buffer to exactly DEPTH is accepted.
- R7: A `clr_ovr` pulse clears `overrun`. If a new overrun occurs on the same edge, `overrun` stays set.
- R8: `rx_avail` is high exactly when `msg_cnt` is nonzero, and clears on the release that empties the FIFO.
- R9: A write beat and a release on the same edge both take effect. The release uses the header that was stored before that edge.
- R10: After a synchronous reset, `byte_cnt`, `msg_cnt`, `rx_avail` and `overrun` are zero.
- R11: `byte_cnt` counts the bytes of accepted messages from their first beat onward, including messages still being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message byte beat valid |
| in_byte | input | 8 | Message byte |
| in_len | input | AW+1 | Total message length, sampled on the first beat |
| rel_cmd | input | 1 | Discard the oldest message |
| clr_ovr | input | 1 | Clear the overrun flag |
| rd_addr | input | WIN_AW | Offset into the oldest message |
| rd_data | output | 8 | Registered window byte |
| byte_cnt | output | AW+1 | Reserved byte count |
| msg_cnt | output | AW+1 | Complete message count |
| rx_avail | output | 1 | At least one message stored |
| overrun | output | 1 | A message was dropped for lack of space |

## Verification
The hardest situation to reach is a full buffer whose pointers have already wrapped. A message must then be refused while another message is being released, or a clear must coincide with a fresh overrun. The bench first wraps the pointers with a long sequence of mixed-format messages. It then fills the buffer to exactly DEPTH with extended messages of chosen lengths, so that the next message is forced into overrun. Separately, it raises a release in the middle of an incoming burst, which exercises the case where the release must use the header of the already-stored message.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_FILL = 2'd1,
    WR_DROP = 2'd2
  } wr_state_e;

  // Bytes occupied by a stored message, decoded from its header byte
  function automatic logic [4:0] hdr_msg_len(input logic [7:0] h);
    logic [4:0] base;
    logic [4:0] data;
    base = h[7] ? 5'd5 : 5'd3;
    data = h[6] ? 5'd0 : {1'b0, h[3:0]};
    return base + data;
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rd_data,
  input  logic [AW-1:0] hdr_addr,
  output logic [7:0]    hdr
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rd_data <= mem[raddr];
  end

  // Second, asynchronous read port for the header at the start pointer
  assign hdr = mem[hdr_addr];

endmodule

// File: rtl/rxf_writer.sv
module rxf_writer
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic [CW-1:0] in_len,
  input  logic [CW-1:0] byte_cnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [CW-1:0] reserve_len,
  output logic          commit,
  output logic          ovr_set
);

  wr_state_e     st_q;
  logic [CW-1:0] remain_q;
  logic [AW-1:0] wr_ptr_q;
  logic          take_first;
  logic          fits;

  always_comb begin
    take_first  = in_valid && (st_q == WR_IDLE) && (in_len != '0);
    fits        = ({1'b0, byte_cnt} + {1'b0, in_len}) <= (CW+1)'(DEPTH);
    mem_we      = (take_first && fits) || (in_valid && (st_q == WR_FILL));
    ovr_set     = take_first && !fits;
    reserve_len = (take_first && fits) ? in_len : '0;
    commit      = mem_we &&
                  (((st_q == WR_IDLE) && (in_len == CW'(1))) ||
                   ((st_q == WR_FILL) && (remain_q == CW'(1))));
    mem_waddr   = wr_ptr_q;
    mem_wdata   = in_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= WR_IDLE;
      remain_q <= '0;
      wr_ptr_q <= '0;
    end else begin
      if (mem_we) begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
      end
      case (st_q)
        WR_IDLE: begin
          if (take_first) begin
            remain_q <= in_len - CW'(1);
            if (in_len != CW'(1)) begin
              st_q <= fits ? WR_FILL : WR_DROP;
            end
          end
        end
        WR_FILL, WR_DROP: begin
          if (in_valid) begin
            remain_q <= remain_q - CW'(1);
            if (remain_q == CW'(1)) begin
              st_q <= WR_IDLE;
            end
          end
        end
        default: st_q <= WR_IDLE;
      endcase
    end
  end

  // R2
  wr_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st_q == WR_FILL) |=> (wr_ptr_q == $past(wr_ptr_q) + 1'b1));

  // R6
  drop_hold_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == WR_DROP) |=> $stable(wr_ptr_q));

endmodule

// File: rtl/rxf_release.sv
module rxf_release
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rel_cmd,
  input  logic          msg_nz,
  input  logic [7:0]    hdr,
  output logic [AW-1:0] start_ptr,
  output logic          rel_fire,
  output logic [CW-1:0] rel_len
);

  logic [AW-1:0] start_q;

  assign rel_fire  = rel_cmd && msg_nz;
  assign rel_len   = CW'(hdr_msg_len(hdr));
  assign start_ptr = start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
    end else if (rel_fire) begin
      start_q <= start_q + rel_len[AW-1:0];
    end
  end

  // R5
  empty_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_cmd && !msg_nz) |=> $stable(start_q));

endmodule

// File: rtl/can_rx_msg_fifo.sv
module can_rx_msg_fifo #(
  parameter int DEPTH  = 64,
  parameter int WIN_AW = 5,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic [CW-1:0]     in_len,
  input  logic              rel_cmd,
  input  logic              clr_ovr,
  input  logic [WIN_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [CW-1:0]     byte_cnt,
  output logic [CW-1:0]     msg_cnt,
  output logic              rx_avail,
  output logic              overrun
);

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic [CW-1:0] reserve_len;
  logic          commit;
  logic          ovr_set;
  logic [AW-1:0] start_ptr;
  logic          rel_fire;
  logic [CW-1:0] rel_len;
  logic [7:0]    hdr;
  logic [CW-1:0] byte_cnt_q;
  logic [CW-1:0] msg_cnt_q;
  logic [CW-1:0] msg_next;
  logic          rx_avail_q;
  logic          overrun_q;

  rxf_writer #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_writer (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_len     (in_len),
    .byte_cnt   (byte_cnt_q),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .reserve_len(reserve_len),
    .commit     (commit),
    .ovr_set    (ovr_set)
  );

  rxf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr   (start_ptr + AW'(rd_addr)),
    .rd_data (rd_data),
    .hdr_addr(start_ptr),
    .hdr     (hdr)
  );

  rxf_release #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_release (
    .clk      (clk),
    .rst      (rst),
    .rel_cmd  (rel_cmd),
    .msg_nz   (msg_cnt_q != '0),
    .hdr      (hdr),
    .start_ptr(start_ptr),
    .rel_fire (rel_fire),
    .rel_len  (rel_len)
  );

  assign msg_next = msg_cnt_q + CW'(commit) - CW'(rel_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_cnt_q <= '0;
      msg_cnt_q  <= '0;
      rx_avail_q <= 1'b0;
      overrun_q  <= 1'b0;
    end else begin
      byte_cnt_q <= byte_cnt_q + reserve_len - (rel_fire ? rel_len : '0);
      msg_cnt_q  <= msg_next;
      rx_avail_q <= (msg_next != '0);
      if (ovr_set) begin
        overrun_q <= 1'b1;
      end else if (clr_ovr) begin
        overrun_q <= 1'b0;
      end
    end
  end

  assign byte_cnt = byte_cnt_q;
  assign msg_cnt  = msg_cnt_q;
  assign rx_avail = rx_avail_q;
  assign overrun  = overrun_q;

  // R11
  byte_bound_chk: assert property (@(posedge clk) disable iff (rst)
    byte_cnt_q <= CW'(DEPTH));

  // R1
  msg_vs_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    ({2'b00, msg_cnt_q} * 3) <= {2'b00, byte_cnt_q});

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun_q && !clr_ovr) |=> overrun_q);

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ovr && !ovr_set) |=> !overrun_q);

  // R5
  empty_counts_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_cmd && msg_cnt_q == '0 && !commit) |=> (msg_cnt_q == '0));

endmodule

// File: tb/test_can_rx_msg_fifo.sv
module test_can_rx_msg_fifo;

  localparam int DEPTH = 64;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = '0;
  logic [CW-1:0] in_len = '0;
  logic          rel_cmd = 1'b0;
  logic          clr_ovr = 1'b0;
  logic [4:0]    rd_addr = '0;
  logic [7:0]    rd_data;
  logic [CW-1:0] byte_cnt;
  logic [CW-1:0] msg_cnt;
  logic          rx_avail;
  logic          overrun;

  int n_total = 0;
  int n_fail  = 0;

  // reference state
  logic [7:0] mm [DEPTH];
  int mstart = 0, mbytes = 0, mmsgs = 0, wptr = 0, mode = 0, remain = 0;
  logic movr = 1'b0;

  always #5 clk = ~clk;

  can_rx_msg_fifo i_can_rx_msg_fifo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_len(in_len), .rel_cmd(rel_cmd), .clr_ovr(clr_ovr),
    .rd_addr(rd_addr), .rd_data(rd_data), .byte_cnt(byte_cnt),
    .msg_cnt(msg_cnt), .rx_avail(rx_avail), .overrun(overrun)
  );

  function automatic int hlen(input logic [7:0] h);
    return (h[7] ? 5 : 3) + (h[6] ? 0 : int'(h[3:0]));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b, input int len,
                      input logic rel, input logic clr);
    int rl;
    int res;
    int com;
    logic set;
    @(negedge clk);
    in_valid = v; in_byte = b; in_len = CW'(len); rel_cmd = rel; clr_ovr = clr;
    @(posedge clk);
    #1;
    rl = (mmsgs > 0) ? hlen(mm[mstart]) : 0;
    res = 0; com = 0; set = 1'b0;
    if (v) begin
      if (mode == 0 && len != 0) begin
        if (mbytes + len > DEPTH) begin
          set = 1'b1;
          if (len > 1) begin mode = 2; remain = len - 1; end
        end else begin
          mm[wptr] = b; wptr = (wptr + 1) % DEPTH; res = len;
          if (len == 1) com = 1; else begin mode = 1; remain = len - 1; end
        end
      end else if (mode == 1) begin
        mm[wptr] = b; wptr = (wptr + 1) % DEPTH; remain--;
        if (remain == 0) begin com = 1; mode = 0; end
      end else if (mode == 2) begin
        remain--;
        if (remain == 0) mode = 0;
      end
    end
    if (rel && mmsgs > 0) begin
      mstart = (mstart + rl) % DEPTH;
      mbytes = mbytes - rl;
      mmsgs--;
    end
    mbytes += res;
    mmsgs += com;
    if (set) movr = 1'b1;
    else if (clr) movr = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 0, 1'b0, 1'b0);
  endtask

  function automatic logic [7:0] mbyte(input int seed, input int i,
                                       input logic [7:0] h);
    if (i == 0) return h;
    return 8'((seed * 29 + i * 11 + 3) & 255);
  endfunction

  // send one message; rel_beat >= 0 raises release on that beat (R9)
  task automatic push_msg(input logic ext, input logic rtr, input int dlc,
                          input int seed, input int rel_beat);
    logic [7:0] h;
    int len;
    h = {ext, rtr, 2'b00, 4'(dlc)};
    len = hlen(h);
    for (int i = 0; i < len; i++)
      step(1'b1, mbyte(seed, i, h), (i == 0) ? len : 0, i == rel_beat, 1'b0);
  endtask

  task automatic check_state(input string tag);
    check({tag, " byte_cnt"}, int'(byte_cnt), mbytes);
    check({tag, " msg_cnt"}, int'(msg_cnt), mmsgs);
    check({tag, " rx_avail"}, int'(rx_avail), int'(mmsgs != 0));
    check({tag, " overrun"}, int'(overrun), int'(movr));
  endtask

  task automatic read_chk(input int addr, input string tag);
    rd_addr = 5'(addr);
    idle();
    check(tag, int'(rd_data), int'(mm[(mstart + addr) % DEPTH]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    check("R10 byte_cnt", int'(byte_cnt), 0);
    check("R10 msg_cnt", int'(msg_cnt), 0);
    check("R10 rx_avail", int'(rx_avail), 0);
    check("R10 overrun", int'(overrun), 0);

    // R5 release on empty, then header must sit at offset 0 of a new message
    step(1'b0, 8'h00, 0, 1'b1, 1'b0);
    check_state("R5 empty release");
    push_msg(1'b0, 1'b0, 2, 1, -1);
    read_chk(0, "R5 start unmoved");
    step(1'b0, 8'h00, 0, 1'b1, 1'b0);
    check_state("R8 emptied");

    // R1 R2 R3 R4 sweep over every header format
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d <= 8; d++) begin
          push_msg(1'(e), 1'(r), d, e * 40 + r * 20 + d, -1);
          check_state("R2 R11 after push");
          for (int a = 0; a < (e ? 5 : 3) + (r ? 0 : d); a++)
            read_chk(a, "R3 window byte");
          step(1'b0, 8'h00, 0, 1'b1, 1'b0);
          check_state("R4 R1 after release");
        end

    // R4 wrap: keep two messages in flight across many pointer wraps
    for (int i = 0; i < 60; i++) begin
      push_msg(1'(i % 2), 1'(i % 5 == 0), i % 9, i + 100, -1);
      if (mmsgs > 2) begin
        step(1'b0, 8'h00, 0, 1'b1, 1'b0);
        check_state("R4 wrap release");
        read_chk(0, "R3 wrap header");
        read_chk(3, "R3 wrap byte");
      end
    end
    while (mmsgs > 0) step(1'b0, 8'h00, 0, 1'b1, 1'b0);
    check_state("R8 drained");

    // R9 write and release on the same edges
    push_msg(1'b1, 1'b0, 4, 7, -1);
    push_msg(1'b0, 1'b0, 8, 8, -1);
    push_msg(1'b0, 1'b1, 0, 9, 0);
    check_state("R9 release on first beat");
    push_msg(1'b1, 1'b0, 8, 10, 12);
    check_state("R9 release on last beat");
    read_chk(0, "R9 head header");
    read_chk(1, "R9 head byte");
    while (mmsgs > 0) step(1'b0, 8'h00, 0, 1'b1, 1'b0);

    // R6 fill to exactly DEPTH: 4 x 13 + 12 = 64
    for (int i = 0; i < 4; i++) push_msg(1'b1, 1'b0, 8, 200 + i, -1);
    push_msg(1'b1, 1'b0, 7, 210, -1);
    check_state("R6 exact fit");
    check("R6 exact fit bytes", int'(byte_cnt), 64);
    push_msg(1'b0, 1'b1, 0, 211, -1);
    check_state("R6 overrun drop");
    check("R6 overrun flag", int'(overrun), 1);
    // R7 clear on the same edge as a new overrun: set wins
    step(1'b1, 8'h40, 3, 1'b0, 1'b1);
    step(1'b1, 8'h11, 0, 1'b0, 1'b0);
    step(1'b1, 8'h22, 0, 1'b0, 1'b0);
    check("R7 set wins", int'(overrun), 1);
    step(1'b0, 8'h00, 0, 1'b0, 1'b1);
    check("R7 cleared", int'(overrun), 0);
    read_chk(0, "R6 head intact");
    // release during a dropped burst
    step(1'b1, 8'h00, 13, 1'b1, 1'b0);
    for (int i = 1; i < 13; i++) step(1'b1, 8'(i), 0, 1'b0, 1'b0);
    check_state("R6 R9 drop with release");
    push_msg(1'b1, 1'b0, 8, 220, -1);
    check_state("R6 fits after release");
    while (mmsgs > 0) begin
      read_chk(0, "R3 drain header");
      step(1'b0, 8'h00, 0, 1'b1, 1'b0);
    end
    check_state("R8 final empty");

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule